// File: doc/BRIEF.md
# Adaptive Context Probability State Store

This block keeps the adaptive probability state of an MQ-style binary arithmetic coder. Each coding context holds a probability state index and its current more-probable-symbol (MPS) value. A fixed 47-state transition table, indexed by the state index, gives four things: the LPS probability estimate Qe, the next state after an MPS, the next state after an LPS, and a flag that marks states where the sense of the MPS must be inverted after an LPS.

The coder requests a context by number together with the decision bit it is about to code. One clock cycle later the block returns the context's index and MPS, the four table values for that index, and whether the decision is the less probable symbol. After the coder has finished a symbol, it reports the context, whether an LPS was coded and whether the interval was renormalized. The block then moves that context to its next state. A read and an update may occur in the same cycle. If they name the same context, the read returns the state after the update.

Top module: `mq_ctx_state`

## Requirements
- R1: After reset every context has MPS 0. Context 18 (uniform) holds index 46, context 17 (run-length) holds index 3, context 0 (all-zero neighbourhood) holds index 4, and every other context holds index 0.
- R2: `rsp_valid` is 1 in exactly the cycle after a cycle with `rd_en` high. In any cycle without `rd_en`, all response outputs keep their values.
- R3: The response carries the context's index and the table entry for that index: `rsp_qe`, `rsp_nmps`, `rsp_nlps` and `rsp_switch`. Some entries are state 0 = (0x5601, 1, 1, 1), state 1 = (0x3401, 2, 6, 0), state 5 = (0x0221, 38, 33, 0) and state 46 = (0x5601, 46, 46, 0). `rsp_switch` is 1 only for states 0, 6 and 14.
- R4: `rsp_lps` is 1 when the requested decision `rd_d` differs from the context's MPS.
- R5: An update with `upd_renorm` = 1 writes the context's index. The new index is the next-after-MPS entry when `upd_lps` = 0 and the next-after-LPS entry when `upd_lps` = 1.
- R6: An update with `upd_renorm` = 0 leaves the context's index unchanged.
- R7: An update inverts the context's MPS exactly when `upd_lps` = 1 and the switch flag of the context's current index is 1. This holds whatever the value of `upd_renorm`.
- R8: When a read and an update name the same context in the same cycle, the response reflects the state after that update.
- R9: Context numbers 19 and above are outside the store. An update naming one of them changes no context. A read of one of them returns index 0, MPS 0 and the state-0 table entry.
- R10: An update changes only the context it names. All other contexts keep their index and MPS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads the starting state of all contexts |
| rd_en | input | 1 | Read request |
| rd_ctx | input | 5 | Context number to read |
| rd_d | input | 1 | Decision about to be coded in that context |
| upd_en | input | 1 | Update request |
| upd_ctx | input | 5 | Context number to update |
| upd_lps | input | 1 | 1 when the coded symbol was the LPS |
| upd_renorm | input | 1 | 1 when the interval was renormalized |
| rsp_valid | output | 1 | Response registers hold a fresh read |
| rsp_idx | output | 6 | Probability state index of the context |
| rsp_mps | output | 1 | MPS value of the context |
| rsp_lps | output | 1 | Decision is the less probable symbol |
| rsp_qe | output | 16 | LPS probability estimate for the index |
| rsp_nmps | output | 6 | Next index after an MPS |
| rsp_nlps | output | 6 | Next index after an LPS |
| rsp_switch | output | 1 | MPS inversion flag for the index |

## Verification
The bench builds the block with its default parameters: 19 contexts, a 5-bit context number and a 6-bit state index. With a 5-bit number, context codes 19 to 31 can be driven, so updates and reads outside the store are easy to reach. Random context numbers are drawn up to 22, so these cases occur often. Long random runs of LPS-and-renorm updates walk contexts into the switch states 0, 6 and 14 and down to the deep states near 45. Forced same-cycle read and update collisions cover the bypass path.

// File: rtl/mq_ctx_pkg.sv
package mq_ctx_pkg;

  localparam int IDX_W      = 6;
  localparam int QE_W       = 16;
  localparam int NUM_STATES = 47;

  typedef struct packed {
    logic [QE_W-1:0]  qe;
    logic [IDX_W-1:0] nmps;
    logic [IDX_W-1:0] nlps;
    logic             sw;
  } mq_entry_t;

  function automatic mq_entry_t mk(input logic [QE_W-1:0] q, input int nm,
                                   input int nl, input logic s);
    mq_entry_t e;
    e.qe   = q;
    e.nmps = IDX_W'(nm);
    e.nlps = IDX_W'(nl);
    e.sw   = s;
    return e;
  endfunction

  // State transition table of the adaptive estimator.
  function automatic mq_entry_t mq_lookup(input logic [IDX_W-1:0] i);
    case (i)
      6'd1:  return mk(16'h3401,  2,  6, 1'b0);
      6'd2:  return mk(16'h1801,  3,  9, 1'b0);
      6'd3:  return mk(16'h0AC1,  4, 12, 1'b0);
      6'd4:  return mk(16'h0521,  5, 29, 1'b0);
      6'd5:  return mk(16'h0221, 38, 33, 1'b0);
      6'd6:  return mk(16'h5601,  7,  6, 1'b1);
      6'd7:  return mk(16'h5401,  8, 14, 1'b0);
      6'd8:  return mk(16'h4801,  9, 14, 1'b0);
      6'd9:  return mk(16'h3801, 10, 14, 1'b0);
      6'd10: return mk(16'h3001, 11, 17, 1'b0);
      6'd11: return mk(16'h2401, 12, 18, 1'b0);
      6'd12: return mk(16'h1C01, 13, 20, 1'b0);
      6'd13: return mk(16'h1601, 29, 21, 1'b0);
      6'd14: return mk(16'h5601, 15, 14, 1'b1);
      6'd15: return mk(16'h5401, 16, 14, 1'b0);
      6'd16: return mk(16'h5101, 17, 15, 1'b0);
      6'd17: return mk(16'h4801, 18, 16, 1'b0);
      6'd18: return mk(16'h3801, 19, 17, 1'b0);
      6'd19: return mk(16'h3401, 20, 18, 1'b0);
      6'd20: return mk(16'h3001, 21, 19, 1'b0);
      6'd21: return mk(16'h2801, 22, 19, 1'b0);
      6'd22: return mk(16'h2401, 23, 20, 1'b0);
      6'd23: return mk(16'h2201, 24, 21, 1'b0);
      6'd24: return mk(16'h1C01, 25, 22, 1'b0);
      6'd25: return mk(16'h1801, 26, 23, 1'b0);
      6'd26: return mk(16'h1601, 27, 24, 1'b0);
      6'd27: return mk(16'h1401, 28, 25, 1'b0);
      6'd28: return mk(16'h1201, 29, 26, 1'b0);
      6'd29: return mk(16'h1101, 30, 27, 1'b0);
      6'd30: return mk(16'h0AC1, 31, 28, 1'b0);
      6'd31: return mk(16'h09C1, 32, 29, 1'b0);
      6'd32: return mk(16'h08A1, 33, 30, 1'b0);
      6'd33: return mk(16'h0521, 34, 31, 1'b0);
      6'd34: return mk(16'h0441, 35, 32, 1'b0);
      6'd35: return mk(16'h02A1, 36, 33, 1'b0);
      6'd36: return mk(16'h0221, 37, 34, 1'b0);
      6'd37: return mk(16'h0141, 38, 35, 1'b0);
      6'd38: return mk(16'h0111, 39, 36, 1'b0);
      6'd39: return mk(16'h0085, 40, 37, 1'b0);
      6'd40: return mk(16'h0049, 41, 38, 1'b0);
      6'd41: return mk(16'h0025, 42, 39, 1'b0);
      6'd42: return mk(16'h0015, 43, 40, 1'b0);
      6'd43: return mk(16'h0009, 44, 41, 1'b0);
      6'd44: return mk(16'h0005, 45, 42, 1'b0);
      6'd45: return mk(16'h0001, 45, 43, 1'b0);
      6'd46: return mk(16'h5601, 46, 46, 1'b0);
      default: return mk(16'h5601, 1, 1, 1'b1);  // state 0 and unused codes
    endcase
  endfunction

endpackage

// File: rtl/mq_state_table.sv
module mq_state_table
  import mq_ctx_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  output mq_entry_t        entry
);
  always_comb entry = mq_lookup(idx);
endmodule

// File: rtl/mq_ctx_store.sv
module mq_ctx_store
  import mq_ctx_pkg::*;
#(
  parameter int NUM_CTX  = 19,
  parameter int CTX_W    = $clog2(NUM_CTX),
  parameter int UNI_CTX  = 18,
  parameter int RUN_CTX  = 17,
  parameter int ZERO_CTX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [CTX_W-1:0] upd_ctx,
  input  logic             upd_lps,
  input  logic             upd_renorm,
  input  mq_entry_t        upd_entry,    // table entry of upd_cur_idx
  output logic [IDX_W-1:0] upd_cur_idx,
  output logic             upd_cur_mps,
  input  logic [CTX_W-1:0] rd_ctx,
  output logic [IDX_W-1:0] rd_idx,       // state after this cycle's update
  output logic             rd_mps
);

  function automatic logic [IDX_W-1:0] start_idx(input int c);
    if (c == UNI_CTX)  return IDX_W'(46);
    if (c == RUN_CTX)  return IDX_W'(3);
    if (c == ZERO_CTX) return IDX_W'(4);
    return '0;
  endfunction

  logic [IDX_W-1:0] idx_q [NUM_CTX];
  logic             mps_q [NUM_CTX];
  logic [IDX_W-1:0] idx_d [NUM_CTX];
  logic             mps_d [NUM_CTX];

  logic [IDX_W-1:0] upd_next_idx;
  assign upd_next_idx = upd_lps ? upd_entry.nlps : upd_entry.nmps;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic hit;
    assign hit = upd_en && (upd_ctx == CTX_W'(c));

    always_comb begin
      idx_d[c] = (hit && upd_renorm) ? upd_next_idx : idx_q[c];
      mps_d[c] = (hit && upd_lps && upd_entry.sw) ? ~mps_q[c] : mps_q[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[c] <= start_idx(c);
        mps_q[c] <= 1'b0;
      end else begin
        idx_q[c] <= idx_d[c];
        mps_q[c] <= mps_d[c];
      end
    end
  end

  // Out-of-range context numbers read as state 0, MPS 0.
  always_comb begin
    upd_cur_idx = '0;
    upd_cur_mps = 1'b0;
    rd_idx      = '0;
    rd_mps      = 1'b0;
    for (int c = 0; c < NUM_CTX; c++) begin
      if (upd_ctx == CTX_W'(c)) begin
        upd_cur_idx = idx_q[c];
        upd_cur_mps = mps_q[c];
      end
      if (rd_ctx == CTX_W'(c)) begin
        rd_idx = idx_d[c];
        rd_mps = mps_d[c];
      end
    end
  end

endmodule

// File: rtl/mq_ctx_state.sv
module mq_ctx_state
  import mq_ctx_pkg::*;
#(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [CTX_W-1:0] rd_ctx,
  input  logic             rd_d,
  input  logic             upd_en,
  input  logic [CTX_W-1:0] upd_ctx,
  input  logic             upd_lps,
  input  logic             upd_renorm,
  output logic             rsp_valid,
  output logic [IDX_W-1:0] rsp_idx,
  output logic             rsp_mps,
  output logic             rsp_lps,
  output logic [QE_W-1:0]  rsp_qe,
  output logic [IDX_W-1:0] rsp_nmps,
  output logic [IDX_W-1:0] rsp_nlps,
  output logic             rsp_switch
);

  // Named internal events, observed by the bound checker.
  logic [IDX_W-1:0] upd_cur_idx;
  logic             upd_cur_mps;
  logic             upd_cur_sw;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_mps;
  mq_entry_t        upd_entry;
  mq_entry_t        rd_entry;

  mq_ctx_store #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (upd_en),
    .upd_ctx    (upd_ctx),
    .upd_lps    (upd_lps),
    .upd_renorm (upd_renorm),
    .upd_entry  (upd_entry),
    .upd_cur_idx(upd_cur_idx),
    .upd_cur_mps(upd_cur_mps),
    .rd_ctx     (rd_ctx),
    .rd_idx     (rd_idx),
    .rd_mps     (rd_mps)
  );

  mq_state_table u_tbl_upd (.idx(upd_cur_idx), .entry(upd_entry));
  mq_state_table u_tbl_rd  (.idx(rd_idx),      .entry(rd_entry));

  assign upd_cur_sw = upd_entry.sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_idx    <= '0;
      rsp_mps    <= 1'b0;
      rsp_lps    <= 1'b0;
      rsp_qe     <= '0;
      rsp_nmps   <= '0;
      rsp_nlps   <= '0;
      rsp_switch <= 1'b0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        rsp_idx    <= rd_idx;
        rsp_mps    <= rd_mps;
        rsp_lps    <= rd_d ^ rd_mps;
        rsp_qe     <= rd_entry.qe;
        rsp_nmps   <= rd_entry.nmps;
        rsp_nlps   <= rd_entry.nlps;
        rsp_switch <= rd_entry.sw;
      end
    end
  end

endmodule

// File: rtl/mq_ctx_state_chk.sv
module mq_ctx_state_chk #(
  parameter int NUM_CTX = 19,
  parameter int CTX_W   = 5,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [CTX_W-1:0] rd_ctx,
  input logic             rd_d,
  input logic             upd_en,
  input logic [CTX_W-1:0] upd_ctx,
  input logic             upd_lps,
  input logic             upd_renorm,
  input logic             rsp_valid,
  input logic [IDX_W-1:0] rsp_idx,
  input logic             rsp_mps,
  input logic             rsp_lps,
  input logic [15:0]      rsp_qe,
  input logic [IDX_W-1:0] rsp_nmps,
  input logic [IDX_W-1:0] rsp_nlps,
  input logic             rsp_switch,
  input logic [IDX_W-1:0] upd_cur_idx,
  input logic             upd_cur_mps,
  input logic             upd_cur_sw
);
  localparam logic [CTX_W:0] LIM = (CTX_W+1)'(NUM_CTX);

  logic same_ctx;
  assign same_ctx = rd_en && upd_en && (rd_ctx == upd_ctx) && ({1'b0, upd_ctx} < LIM);

  a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rsp_qe) && $stable(rsp_idx) && $stable(rsp_mps) && $stable(rsp_lps)));
  a_r3_switch_states_qe: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_switch) |-> rsp_qe == 16'h5601);
  a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_idx <= IDX_W'(46) && rsp_nmps <= IDX_W'(46) && rsp_nlps <= IDX_W'(46)));
  a_r4_lps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_lps == ($past(rd_d) ^ rsp_mps));
  a_r6_index_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (same_ctx && !upd_renorm) |=> rsp_idx == $past(upd_cur_idx));
  a_r7_mps_inversion: assert property (@(posedge clk) disable iff (!rst_n)
    same_ctx |=> rsp_mps == ($past(upd_cur_mps) ^ ($past(upd_lps) & $past(upd_cur_sw))));
endmodule

bind mq_ctx_state mq_ctx_state_chk #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W), .IDX_W(mq_ctx_pkg::IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ctx(rd_ctx), .rd_d(rd_d),
  .upd_en(upd_en), .upd_ctx(upd_ctx), .upd_lps(upd_lps), .upd_renorm(upd_renorm),
  .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_mps(rsp_mps), .rsp_lps(rsp_lps),
  .rsp_qe(rsp_qe), .rsp_nmps(rsp_nmps), .rsp_nlps(rsp_nlps), .rsp_switch(rsp_switch),
  .upd_cur_idx(upd_cur_idx), .upd_cur_mps(upd_cur_mps), .upd_cur_sw(upd_cur_sw)
);

// File: tb/test_mq_ctx_state.sv
module test_mq_ctx_state;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_en = 1'b0, rd_d = 1'b0, upd_en = 1'b0, upd_lps = 1'b0, upd_renorm = 1'b0;
  logic [4:0] rd_ctx = '0, upd_ctx = '0;
  logic       rsp_valid, rsp_mps, rsp_lps, rsp_switch;
  logic [5:0] rsp_idx, rsp_nmps, rsp_nlps;
  logic [15:0] rsp_qe;

  int n_tests = 0;
  int n_fail  = 0;
  int m_idx [19];
  bit m_mps [19];

  always #10 clk = ~clk;  // 50 MHz

  mq_ctx_state i_mq_ctx_state (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_ctx(rd_ctx), .rd_d(rd_d),
    .upd_en(upd_en), .upd_ctx(upd_ctx), .upd_lps(upd_lps), .upd_renorm(upd_renorm),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_mps(rsp_mps), .rsp_lps(rsp_lps),
    .rsp_qe(rsp_qe), .rsp_nmps(rsp_nmps), .rsp_nlps(rsp_nlps), .rsp_switch(rsp_switch)
  );

  // Bench table packed as {qe, nmps, nlps, sw}.
  function automatic logic [28:0] tb_tab(input int s);
    logic [15:0] q; int a, b; bit w;
    w = (s == 0 || s == 6 || s == 14);
    case (s)
      0:  begin q = 16'h5601; a = 1;  b = 1;  end
      1:  begin q = 16'h3401; a = 2;  b = 6;  end
      2:  begin q = 16'h1801; a = 3;  b = 9;  end
      3:  begin q = 16'h0AC1; a = 4;  b = 12; end
      4:  begin q = 16'h0521; a = 5;  b = 29; end
      5:  begin q = 16'h0221; a = 38; b = 33; end
      6:  begin q = 16'h5601; a = 7;  b = 6;  end
      7:  begin q = 16'h5401; a = 8;  b = 14; end
      8:  begin q = 16'h4801; a = 9;  b = 14; end
      9:  begin q = 16'h3801; a = 10; b = 14; end
      10: begin q = 16'h3001; a = 11; b = 17; end
      11: begin q = 16'h2401; a = 12; b = 18; end
      12: begin q = 16'h1C01; a = 13; b = 20; end
      13: begin q = 16'h1601; a = 29; b = 21; end
      14: begin q = 16'h5601; a = 15; b = 14; end
      15: begin q = 16'h5401; a = 16; b = 14; end
      16: begin q = 16'h5101; a = 17; b = 15; end
      17: begin q = 16'h4801; a = 18; b = 16; end
      18: begin q = 16'h3801; a = 19; b = 17; end
      19: begin q = 16'h3401; a = 20; b = 18; end
      20: begin q = 16'h3001; a = 21; b = 19; end
      21: begin q = 16'h2801; a = 22; b = 19; end
      22: begin q = 16'h2401; a = 23; b = 20; end
      23: begin q = 16'h2201; a = 24; b = 21; end
      24: begin q = 16'h1C01; a = 25; b = 22; end
      25: begin q = 16'h1801; a = 26; b = 23; end
      26: begin q = 16'h1601; a = 27; b = 24; end
      27: begin q = 16'h1401; a = 28; b = 25; end
      28: begin q = 16'h1201; a = 29; b = 26; end
      29: begin q = 16'h1101; a = 30; b = 27; end
      30: begin q = 16'h0AC1; a = 31; b = 28; end
      31: begin q = 16'h09C1; a = 32; b = 29; end
      32: begin q = 16'h08A1; a = 33; b = 30; end
      33: begin q = 16'h0521; a = 34; b = 31; end
      34: begin q = 16'h0441; a = 35; b = 32; end
      35: begin q = 16'h02A1; a = 36; b = 33; end
      36: begin q = 16'h0221; a = 37; b = 34; end
      37: begin q = 16'h0141; a = 38; b = 35; end
      38: begin q = 16'h0111; a = 39; b = 36; end
      39: begin q = 16'h0085; a = 40; b = 37; end
      40: begin q = 16'h0049; a = 41; b = 38; end
      41: begin q = 16'h0025; a = 42; b = 39; end
      42: begin q = 16'h0015; a = 43; b = 40; end
      43: begin q = 16'h0009; a = 44; b = 41; end
      44: begin q = 16'h0005; a = 45; b = 42; end
      45: begin q = 16'h0001; a = 45; b = 43; end
      default: begin q = 16'h5601; a = 46; b = 46; end
    endcase
    return {q, 6'(a), 6'(b), w};
  endfunction

  // R1 starting indices.
  function automatic int tb_start(input int c);
    return (c == 18) ? 46 : (c == 17) ? 3 : (c == 0) ? 4 : 0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 19; c++) begin
      m_idx[c] = tb_start(c);
      m_mps[c] = 1'b0;
    end
  endtask

  // One cycle: drive at negedge, model update then read, check at next negedge.
  task automatic step(input bit re, input int rc, input bit d,
                      input bit ue, input int uc, input bit lps, input bit rn,
                      input string tag);
    logic [28:0] t;
    int ei; bit em;
    rd_en = re; rd_ctx = 5'(rc); rd_d = d;
    upd_en = ue; upd_ctx = 5'(uc); upd_lps = lps; upd_renorm = rn;
    if (ue && uc < 19) begin  // R5 R6 R7 R9 R10
      t = tb_tab(m_idx[uc]);
      if (lps && t[0]) m_mps[uc] = ~m_mps[uc];
      if (rn) m_idx[uc] = lps ? int'(t[6:1]) : int'(t[12:7]);
    end
    ei = (rc < 19) ? m_idx[rc] : 0;
    em = (rc < 19) ? m_mps[rc] : 1'b0;
    @(negedge clk);
    if (re) begin
      t = tb_tab(ei);
      check({tag, " R2 valid"}, int'(rsp_valid), 1);
      check({tag, " idx"}, int'(rsp_idx), ei);
      check({tag, " mps"}, int'(rsp_mps), int'(em));
      check({tag, " R4 lps"}, int'(rsp_lps), int'(d ^ em));
      check({tag, " R3 qe"}, int'(rsp_qe), int'(t[28:13]));
      check({tag, " R3 nmps"}, int'(rsp_nmps), int'(t[12:7]));
      check({tag, " R3 nlps"}, int'(rsp_nlps), int'(t[6:1]));
      check({tag, " R3 switch"}, int'(rsp_switch), int'(t[0]));
    end
  endtask

  task automatic read_all(input string tag);
    for (int c = 0; c < 19; c++) step(1, c, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] hq; logic [5:0] hi;
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check("R2 reset valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    read_all("R1 start");
    step(1, 18, 1, 0, 0, 0, 0, "R3 state46 R4");

    // R5 MPS with renorm on context 5 (state 0 -> 1)
    step(0, 0, 0, 1, 5, 0, 1, "R5 mps");
    step(1, 5, 0, 0, 0, 0, 0, "R5 mps read");
    // R6 no renorm: index unchanged
    step(0, 0, 0, 1, 5, 0, 0, "R6 norenorm");
    step(1, 5, 0, 0, 0, 0, 0, "R6 read");
    // R7 LPS at switch state 0 on context 6 without renorm: MPS flips, idx kept
    step(0, 0, 0, 1, 6, 1, 0, "R7 flip norenorm");
    step(1, 6, 1, 0, 0, 0, 0, "R7 read");
    // R7 LPS at state 1 (no switch) with renorm: idx -> 6, MPS kept
    step(0, 0, 0, 1, 5, 1, 1, "R7 noflip");
    step(1, 5, 0, 0, 0, 0, 0, "R7 R5 lps read");
    // R8 same-cycle bypass
    step(1, 7, 1, 1, 7, 1, 1, "R8 bypass");
    step(1, 7, 0, 1, 7, 0, 1, "R8 bypass2");
    // R9 out of range update and read, R10 isolation
    step(1, 25, 1, 1, 19, 1, 1, "R9 oor");
    step(1, 31, 0, 1, 31, 1, 1, "R9 oor2");
    read_all("R9 R10 after");
    // R2 hold when idle
    step(1, 18, 0, 0, 0, 0, 0, "R2 pre-hold");
    hq = rsp_qe; hi = rsp_idx;
    step(0, 3, 1, 1, 3, 1, 1, "R2 idle");
    check("R2 idle valid", int'(rsp_valid), 0);
    check("R2 hold qe", int'(rsp_qe), int'(hq));
    check("R2 hold idx", int'(rsp_idx), int'(hi));

    // Random run, LPS-heavy to reach switch and deep states.
    for (int k = 0; k < 4000; k++) begin
      int rc, uc; bit lps;
      rc = (k % 5 == 0) ? 0 : int'($urandom_range(22, 0));
      uc = (k % 7 == 0) ? rc : int'($urandom_range(22, 0));
      lps = ($urandom_range(9, 0) < 3);
      step(1'($urandom_range(1, 0)) | (k % 3 == 0), rc, 1'($urandom_range(1, 0)),
           1'($urandom_range(3, 0) != 0), uc, lps, lps | 1'($urandom_range(1, 0)),
           "R5 R7 R8 R10 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    read_all("R10 final");

    // Reset again returns to starting state (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check("R2 reset valid again", int'(rsp_valid), 0);
    rst_n = 1'b1;
    model_reset();
    read_all("R1 after reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule